// File: doc/BRIEF.md
# Multi-Channel In-Order Mailbox FIFO

This block carries data words from a sending agent to a receiving agent over a set of independent FIFO channels. Every channel has the same depth. The sender pushes a word into a chosen channel whenever that channel has room, so it never waits for earlier words to be consumed. The receiver pops words from a chosen channel and always gets them in the order they were pushed. A word can carry an acknowledge-request mark. When the receiver pops a marked word, a per-channel acknowledge interrupt toward the sender is raised.

Each channel drives several level interrupts:
- A receive interrupt while the channel holds data.
- A low-tide interrupt and a high-tide interrupt, each set against a programmable occupancy threshold.
- A flush-done interrupt, raised after a flush request has emptied the channel in one cycle.

Sticky overflow and underflow flags record a push to a full channel and a pop from an empty channel. A combined line summarises the events of all channels. Two constant outputs report the channel count and the depth, so software can discover both at run time.

Top module: `mbxfifo_top`

## Requirements
- R1: Words popped from a channel appear on `popData` in push order. The word is registered and is valid in the cycle after the clock edge that takes `popReq`.
- R2: A channel accepts up to DEPTH pushes without any pop in between. A push to a full channel is dropped and sets that channel's bit of `ovfFlag`. The bit stays set until a 1 is written to the same bit of `errClr`.
- R3: A pop from an empty channel returns 0 on `popData` and sets that channel's sticky bit of `udfFlag`. Writing 1 to `errClr` clears the bit.
- R4: Each stored word keeps its `pushAckReq` bit. Popping a word whose bit is 1 sets `irqTxAck` for that channel. Popping a word whose bit is 0 leaves `irqTxAck` unchanged. Writing 1 to `ackClr` clears the bit.
- R5: `irqLowTide[c]` is 1 exactly while the occupancy of channel c is at or below `lowThr`.
- R6: `irqHighTide[c]` is 1 exactly while the occupancy of channel c is at or above `highThr`.
- R7: Asserting `flushReq[c]` for one clock discards every entry of channel c at that edge and sets `irqFlush[c]`. `irqFlush[c]` stays set until a 1 is written to `flushClr[c]`. Any push or pop to the channel in the flush cycle is ignored.
- R8: `irqRxXfer[c]` is 1 exactly while channel c holds at least one word.
- R9: `irqCombined` is the OR, over all channels, of the receive, acknowledge, flush-done, high-tide, overflow and underflow bits. Low tide is excluded, so the line is 0 when all channels are empty and clean and `highThr` is above 0.
- R10: Channels are independent: pushing to or popping from one channel changes no status bit of another channel.
- R11: `cfgChanCount` equals NUM_CH and `cfgDepth` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push strobe |
| pushCh | input | CH_W | Channel to push into |
| pushData | input | DATA_W | Word to push |
| pushAckReq | input | 1 | Request acknowledgement for this word |
| popReq | input | 1 | Pop strobe |
| popCh | input | CH_W | Channel to pop from |
| popData | output | DATA_W | Registered popped word, 0 on underflow |
| lowThr | input | CNT_W | Low-tide threshold |
| highThr | input | CNT_W | High-tide threshold |
| flushReq | input | NUM_CH | Per-channel flush request |
| flushClr | input | NUM_CH | Write-1 clear of flush-done |
| ackClr | input | NUM_CH | Write-1 clear of acknowledge pending |
| errClr | input | NUM_CH | Write-1 clear of overflow and underflow |
| irqRxXfer | output | NUM_CH | Channel holds data |
| irqTxAck | output | NUM_CH | Acknowledge pending toward sender |
| irqLowTide | output | NUM_CH | Occupancy at or below lowThr |
| irqHighTide | output | NUM_CH | Occupancy at or above highThr |
| irqFlush | output | NUM_CH | Flush done pending |
| irqCombined | output | 1 | OR of all channel events |
| ovfFlag | output | NUM_CH | Sticky overflow |
| udfFlag | output | NUM_CH | Sticky underflow |
| cfgChanCount | output | 7 | Number of channels |
| cfgDepth | output | 16 | Entries per channel |

## Verification
All state, including `popData`, changes at the edge that takes a strobe. The status outputs are decoded combinationally from that state, so every push, pop, flush or clear result is due one cycle after the stimulus. The bench drives each strobe for one edge and samples one time unit after that edge, before any further input changes. The threshold outputs depend on the threshold inputs without a clock, so the threshold sweep changes `lowThr` and `highThr` between edges and samples after a short delay with no edge in between.

// File: rtl/mbxfifo_pkg.sv
package mbxfifo_pkg;
  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic wr;
    logic rd;
    logic flush;
  } chStrobe_t;
endpackage

// File: rtl/mbxfifo_datapath.sv
module mbxfifo_datapath
  import mbxfifo_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  chStrobe_t [NUM_CH-1:0]               strobes,
  input  logic      [DATA_W:0]                 wrWord,
  output logic      [NUM_CH-1:0][CNT_W-1:0]    level,
  output logic      [NUM_CH-1:0][DATA_W:0]     headWord
);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [DATA_W:0] mem [DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else if (strobes[c].flush) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (strobes[c].wr) begin
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (strobes[c].rd) begin
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        end
        count <= count + CNT_W'(strobes[c].wr) - CNT_W'(strobes[c].rd);
      end
    end

    always_ff @(posedge clk) begin
      if (strobes[c].wr && !strobes[c].flush) begin
        mem[wrPtr] <= wrWord;
      end
    end

    assign level[c]    = count;
    assign headWord[c] = mem[rdPtr];
  end

endmodule

// File: rtl/mbxfifo_ctrl.sv
module mbxfifo_ctrl
  import mbxfifo_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              pushValid,
  input  logic [CH_W-1:0]                   pushCh,
  input  logic                              popReq,
  input  logic [CH_W-1:0]                   popCh,
  input  logic [CNT_W-1:0]                  lowThr,
  input  logic [CNT_W-1:0]                  highThr,
  input  logic [NUM_CH-1:0]                 flushReq,
  input  logic [NUM_CH-1:0]                 flushClr,
  input  logic [NUM_CH-1:0]                 ackClr,
  input  logic [NUM_CH-1:0]                 errClr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      level,
  input  logic [NUM_CH-1:0][DATA_W:0]       headWord,
  output chStrobe_t [NUM_CH-1:0]            strobes,
  output logic [DATA_W-1:0]                 popData,
  output logic [NUM_CH-1:0]                 irqRxXfer,
  output logic [NUM_CH-1:0]                 irqTxAck,
  output logic [NUM_CH-1:0]                 irqLowTide,
  output logic [NUM_CH-1:0]                 irqHighTide,
  output logic [NUM_CH-1:0]                 irqFlush,
  output logic                              irqCombined,
  output logic [NUM_CH-1:0]                 ovfFlag,
  output logic [NUM_CH-1:0]                 udfFlag
);

  logic [NUM_CH-1:0] pushHit, popHit;
  logic [DATA_W-1:0] popNext;

  for (genvar c = 0; c < NUM_CH; c++) begin : gDec
    logic isFull, isEmpty;
    assign isFull     = (level[c] == CNT_W'(DEPTH));
    assign isEmpty    = (level[c] == '0);
    assign pushHit[c] = pushValid && (pushCh == CH_W'(c)) && !flushReq[c];
    assign popHit[c]  = popReq && (popCh == CH_W'(c)) && !flushReq[c];

    assign strobes[c].flush = flushReq[c];
    assign strobes[c].wr    = pushHit[c] && !isFull;
    assign strobes[c].rd    = popHit[c] && !isEmpty;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ovfFlag[c]  <= 1'b0;
        udfFlag[c]  <= 1'b0;
        irqTxAck[c] <= 1'b0;
        irqFlush[c] <= 1'b0;
      end else begin
        ovfFlag[c]  <= (pushHit[c] && isFull)  || (ovfFlag[c] && !errClr[c]);
        udfFlag[c]  <= (popHit[c] && isEmpty)  || (udfFlag[c] && !errClr[c]);
        irqTxAck[c] <= (strobes[c].rd && headWord[c][DATA_W])
                       || (irqTxAck[c] && !ackClr[c]);
        irqFlush[c] <= flushReq[c] || (irqFlush[c] && !flushClr[c]);
      end
    end

    assign irqRxXfer[c]   = !isEmpty;
    assign irqLowTide[c]  = (level[c] <= lowThr);
    assign irqHighTide[c] = (level[c] >= highThr);
  end

  always_comb begin
    popNext = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobes[c].rd) popNext = headWord[c][DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       popData <= '0;
    else if (popReq) popData <= popNext;
  end

  assign irqCombined = |{irqRxXfer, irqTxAck, irqFlush, irqHighTide, ovfFlag, udfFlag};

endmodule

// File: rtl/mbxfifo_top.sv
module mbxfifo_top
  import mbxfifo_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [CH_W-1:0]     pushCh,
  input  logic [DATA_W-1:0]   pushData,
  input  logic                pushAckReq,
  input  logic                popReq,
  input  logic [CH_W-1:0]     popCh,
  output logic [DATA_W-1:0]   popData,
  input  logic [CNT_W-1:0]    lowThr,
  input  logic [CNT_W-1:0]    highThr,
  input  logic [NUM_CH-1:0]   flushReq,
  input  logic [NUM_CH-1:0]   flushClr,
  input  logic [NUM_CH-1:0]   ackClr,
  input  logic [NUM_CH-1:0]   errClr,
  output logic [NUM_CH-1:0]   irqRxXfer,
  output logic [NUM_CH-1:0]   irqTxAck,
  output logic [NUM_CH-1:0]   irqLowTide,
  output logic [NUM_CH-1:0]   irqHighTide,
  output logic [NUM_CH-1:0]   irqFlush,
  output logic                irqCombined,
  output logic [NUM_CH-1:0]   ovfFlag,
  output logic [NUM_CH-1:0]   udfFlag,
  output logic [6:0]          cfgChanCount,
  output logic [15:0]         cfgDepth
);

  chStrobe_t [NUM_CH-1:0]          strobes;
  logic [NUM_CH-1:0][CNT_W-1:0]    level;
  logic [NUM_CH-1:0][DATA_W:0]     headWord;

  mbxfifo_ctrl #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushCh(pushCh),
    .popReq(popReq), .popCh(popCh),
    .lowThr(lowThr), .highThr(highThr),
    .flushReq(flushReq), .flushClr(flushClr), .ackClr(ackClr), .errClr(errClr),
    .level(level), .headWord(headWord), .strobes(strobes),
    .popData(popData),
    .irqRxXfer(irqRxXfer), .irqTxAck(irqTxAck),
    .irqLowTide(irqLowTide), .irqHighTide(irqHighTide),
    .irqFlush(irqFlush), .irqCombined(irqCombined),
    .ovfFlag(ovfFlag), .udfFlag(udfFlag)
  );

  mbxfifo_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN),
    .strobes(strobes),
    .wrWord({pushAckReq, pushData}),
    .level(level), .headWord(headWord)
  );

  assign cfgChanCount = 7'(NUM_CH);
  assign cfgDepth     = 16'(DEPTH);

endmodule

// File: rtl/mbxfifo_chk.sv
module mbxfifo_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              popReq,
  input logic [NUM_CH-1:0] flushReq,
  input logic [NUM_CH-1:0] irqRxXfer,
  input logic [NUM_CH-1:0] irqTxAck,
  input logic [NUM_CH-1:0] irqFlush,
  input logic [NUM_CH-1:0] ovfFlag,
  input logic [NUM_CH-1:0] udfFlag
);

  // R2
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ovfFlag & ~$past(ovfFlag))) |-> $past(pushValid));

  // R3
  udf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(udfFlag & ~$past(udfFlag))) |-> $past(popReq));

  // R4
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqTxAck & ~$past(irqTxAck))) |-> $past(popReq));

  // R7
  flush_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flushReq) |=> ((irqFlush & $past(flushReq)) == $past(flushReq)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flushReq) |=> ((irqRxXfer & $past(flushReq)) == '0));

endmodule

bind mbxfifo_top mbxfifo_chk #(.NUM_CH(NUM_CH)) uChk (.*);

// File: tb/sim_mbxfifo_top.sv
module sim_mbxfifo_top;
  localparam int NC = 2;
  localparam int DP = 4;
  localparam int DW = 8;

  logic clk = 0;
  logic rstN = 0;
  logic pushValid = 0, pushAckReq = 0, popReq = 0;
  logic [0:0] pushCh = 0, popCh = 0;
  logic [DW-1:0] pushData = 0, popData;
  logic [2:0] lowThr = 3'd1, highThr = 3'd3;
  logic [NC-1:0] flushReq = 0, flushClr = 0, ackClr = 0, errClr = 0;
  logic [NC-1:0] irqRxXfer, irqTxAck, irqLowTide, irqHighTide, irqFlush, ovfFlag, udfFlag;
  logic irqCombined;
  logic [6:0] cfgChanCount;
  logic [15:0] cfgDepth;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbxfifo_top #(.NUM_CH(NC), .DEPTH(DP), .DATA_W(DW)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    pushValid = 0; popReq = 0; flushReq = 0; flushClr = 0; ackClr = 0; errClr = 0;
  endtask

  task automatic push(input int ch, input int d, input bit ack);
    pushValid = 1; pushCh = ch[0:0]; pushData = d[DW-1:0]; pushAckReq = ack;
    tick();
  endtask

  task automatic pop(input int ch);
    popReq = 1; popCh = ch[0:0];
    tick();
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick();
    // Reset state
    check("R8 reset rx", irqRxXfer, 0);
    check("R5 reset lowtide", irqLowTide, 3);
    check("R6 reset hightide", irqHighTide, 0);
    check("R9 reset combined", irqCombined, 0);
    check("R2 reset ovf", ovfFlag, 0);
    check("R11 chan count", cfgChanCount, NC);
    check("R11 depth", cfgDepth, DP);

    // Fill both channels, checking tides per level
    for (int ch = 0; ch < NC; ch++) begin
      for (int k = 0; k < DP; k++) begin
        push(ch, ch * 16 + k + 1, k == 2);
        check("R5 fill lowtide", irqLowTide[ch], int'((k + 1) <= 1));
        check("R6 fill hightide", irqHighTide[ch], int'((k + 1) >= 3));
        check("R8 fill rx", irqRxXfer[ch], 1);
      end
      if (ch == 0) begin
        check("R10 other channel untouched", irqRxXfer[1], 0);
        push(0, 8'hEE, 0);
        check("R2 overflow sticky", ovfFlag, 1);
        check("R9 combined on", irqCombined, 1);
        tick();
        check("R2 overflow held", ovfFlag, 1);
        errClr = 2'b01; tick();
        check("R2 overflow cleared", ovfFlag, 0);
      end
    end

    // Drain channel 0 in order
    for (int k = 0; k < DP; k++) begin
      pop(0);
      check("R1 pop order", popData, k + 1);
      check("R4 ack pending", irqTxAck[0], int'(k >= 2));
    end
    check("R10 ch1 still full", irqRxXfer[1], 1);
    pop(0);
    check("R3 underflow data", popData, 0);
    check("R3 underflow flag", udfFlag, 1);
    ackClr = 2'b01; errClr = 2'b01; tick();
    check("R4 ack cleared", irqTxAck, 0);
    check("R3 underflow cleared", udfFlag, 0);

    // Flush channel 1 while full
    flushReq = 2'b10; tick();
    check("R7 flush empties", irqRxXfer[1], 0);
    check("R7 flush done", irqFlush, 2);
    repeat (3) tick();
    check("R7 flush done held", irqFlush, 2);
    pop(1);
    check("R7 entries discarded", popData, 0);
    check("R7 pop after flush underflows", udfFlag, 2);
    flushClr = 2'b10; errClr = 2'b10; tick();
    check("R7 flush cleared", irqFlush, 0);
    check("R9 combined idle", irqCombined, 0);
    highThr = 3'd0; #1;
    check("R9 combined from hightide", irqCombined, 1);

    // Threshold sweep on channel 0 over every level and threshold
    for (int lv = 0; lv <= DP; lv++) begin
      flushReq = 2'b01; tick();
      flushClr = 2'b01; tick();
      for (int k = 0; k < lv; k++) push(0, k, 0);
      for (int t = 0; t <= DP; t++) begin
        lowThr = t[2:0]; highThr = t[2:0]; #1;
        check("R5 sweep lowtide", irqLowTide[0], int'(lv <= t));
        check("R6 sweep hightide", irqHighTide[0], int'(lv >= t));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule